// File: doc/BRIEF.md
# Address Register with Timing-Decoded Control

This block holds the 12-bit memory address of a small accumulator machine. It also contains the gate logic that works out, every cycle, whether the address register loads, clears, increments or keeps its value. The decision comes from the timing-phase lines, the decoded opcode lines, the indirect-addressing bit and the interrupt-cycle flag. The register has no separate enable pins.

There are three possible load sources:
- the program counter, used during an ordinary fetch;
- the address field of the instruction register, used while decoding;
- the word just read from memory, used to follow an indirect reference.

When an interrupt cycle begins, the register is cleared. When the opcode that increments a memory operand reaches its execute phase, the register steps forward by one. The three control strobes are also driven out, so that neighbouring logic and the bench can observe them.

Top module: `addr_reg_gate`

## Requirements
- R1: A synchronous, active-high `rst` sampled on a rising edge sets `ar_q` to 0x000 and takes precedence over every other input.
- R2: The strobes are combinational.
  - `ld_o` = (!intr_cyc & t_slot[0]) | (!intr_cyc & t_slot[2]) | (!op_dec[7] & ind_bit & t_slot[3]).
  - `clr_o` = intr_cyc & t_slot[0].
  - `inc_o` = op_dec[5] & t_slot[4].
- R3: With `intr_cyc`=0 and `t_slot[0]`=1, the next edge loads `pc_in` into `ar_q`.
- R4: With `intr_cyc`=0 and `t_slot[2]`=1, and no fetch load active, the next edge loads `ir_in[11:0]`.
- R5: With `op_dec[7]`=0, `ind_bit`=1 and `t_slot[3]`=1, and no earlier load source active, the next edge loads `mem_in[11:0]`.
- R6: With `intr_cyc`=1 and `t_slot[0]`=1, the next edge sets `ar_q` to 0x000.
- R7: With `op_dec[5]`=1 and `t_slot[4]`=1, and neither clear nor load active, the next edge adds one to `ar_q`. The value 0xFFF wraps to 0x000.
- R8: When several conditions hold in the same cycle, the priorities are as follows.
  - Clear beats load, and load beats increment.
  - Among the load sources, the program counter comes first, then the instruction field, then the memory word.
- R9: When no strobe is active, `ar_q` keeps its value. This includes `op_dec[7]`=1 or `ind_bit`=0 during `t_slot[3]`, and `op_dec[5]` outside `t_slot[4]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| t_slot | input | 8 | Timing-phase lines, bit n is phase n |
| op_dec | input | 8 | Decoded opcode lines, bit n is opcode n |
| ind_bit | input | 1 | Indirect-addressing bit of the current instruction |
| intr_cyc | input | 1 | Interrupt-cycle flag |
| pc_in | input | 12 | Program counter value |
| ir_in | input | 16 | Instruction register; bits 11:0 are the address field |
| mem_in | input | 16 | Word read from memory; bits 11:0 are used |
| ar_q | output | 12 | Address register value |
| ld_o | output | 1 | Derived load strobe |
| inc_o | output | 1 | Derived increment strobe |
| clr_o | output | 1 | Derived clear strobe |

## Verification
With one-hot timing, only one strobe can fire at a time. To make clear and load coincide, the bench raises phases 0 and 3 together while the interrupt flag and an indirect reference are both set. To make load and increment coincide, it raises phases 2 and 4 together while opcode 5 is active. It also pairs load sources (phases 0 with 2, and 2 with 3) to confirm that the program counter comes first, then the instruction field, then the memory word. The scoreboard predicts the winning action from the requirement text and compares the next-cycle `ar_q` with that prediction, and it also checks the three strobes in the same cycle.

// File: rtl/addr_reg_pkg.sv
package addr_reg_pkg;

  // Which source feeds a load
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PC   = 2'd1,
    SRC_IR   = 2'd2,
    SRC_MEM  = 2'd3
  } ar_src_e;

  // The single action the register takes in a cycle
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_BUMP  = 2'd3
  } ar_act_e;

  // Resolve the strobes into one action: clear, then load, then increment
  function automatic ar_act_e pick_action(input logic clr, input logic ld, input logic inc);
    if (clr)      return ACT_CLEAR;
    else if (ld)  return ACT_LOAD;
    else if (inc) return ACT_BUMP;
    else          return ACT_HOLD;
  endfunction

endpackage

// File: rtl/addr_ctl_decode.sv
module addr_ctl_decode
  import addr_reg_pkg::*;
#(
  parameter int unsigned NUM_T    = 8,
  parameter int unsigned NUM_D    = 8,
  parameter int unsigned T_FETCH  = 0,
  parameter int unsigned T_DECODE = 2,
  parameter int unsigned T_INDIR  = 3,
  parameter int unsigned T_EXEC   = 4,
  parameter int unsigned D_REGREF = 7,
  parameter int unsigned D_BUMP   = 5
) (
  input  logic [NUM_T-1:0] t_slot,
  input  logic [NUM_D-1:0] op_dec,
  input  logic             ind_bit,
  input  logic             intr_cyc,
  output logic             ld_o,
  output logic             inc_o,
  output logic             clr_o,
  output ar_src_e          src_o
);

  // Named product terms, each one a separate event
  logic term_fetch;
  logic term_decode;
  logic term_indir;
  logic term_intr;
  logic term_bump;

  assign term_fetch  = !intr_cyc && t_slot[T_FETCH];
  assign term_decode = !intr_cyc && t_slot[T_DECODE];
  assign term_indir  = !op_dec[D_REGREF] && ind_bit && t_slot[T_INDIR];
  assign term_intr   = intr_cyc && t_slot[T_FETCH];
  assign term_bump   = op_dec[D_BUMP] && t_slot[T_EXEC];

  // Sum of products for the three strobes
  assign ld_o  = term_fetch | term_decode | term_indir;
  assign clr_o = term_intr;
  assign inc_o = term_bump;

  // Fixed source order: program counter, then instruction field, then memory word
  always_comb begin
    if (term_fetch)       src_o = SRC_PC;
    else if (term_decode) src_o = SRC_IR;
    else if (term_indir)  src_o = SRC_MEM;
    else                  src_o = SRC_NONE;
  end

endmodule

// File: rtl/addr_reg_core.sv
module addr_reg_core
  import addr_reg_pkg::*;
#(
  parameter int unsigned AR_W   = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic              inc,
  input  logic              clr,
  input  ar_src_e           src,
  input  logic [AR_W-1:0]   pc_val,
  input  logic [DATA_W-1:0] ir_word,
  input  logic [DATA_W-1:0] mem_word,
  output logic [AR_W-1:0]   ar_q
);

  localparam logic [AR_W-1:0] AR_ZERO = '0;
  localparam logic [AR_W-1:0] AR_ONE  = {{(AR_W-1){1'b0}}, 1'b1};

  // Add one in a fixed width, so the top value wraps to zero
  function automatic logic [AR_W-1:0] f_bump(input logic [AR_W-1:0] v);
    return v + AR_ONE;
  endfunction

  logic [AR_W-1:0] ir_field;
  logic [AR_W-1:0] mem_field;

  // Fit the address field of a data word to the register width
  generate
    if (DATA_W >= AR_W) begin : g_slice
      assign ir_field  = ir_word[AR_W-1:0];
      assign mem_field = mem_word[AR_W-1:0];
    end else begin : g_extend
      assign ir_field  = {{(AR_W-DATA_W){1'b0}}, ir_word};
      assign mem_field = {{(AR_W-DATA_W){1'b0}}, mem_word};
    end
  endgenerate

  logic [AR_W-1:0] load_val;
  always_comb begin
    unique case (src)
      SRC_PC:  load_val = pc_val;
      SRC_IR:  load_val = ir_field;
      SRC_MEM: load_val = mem_field;
      default: load_val = AR_ZERO;
    endcase
  end

  ar_act_e act;
  assign act = pick_action(clr, ld, inc);

  // Per-cycle events, brought out for the assertions
  logic ev_clear, ev_load, ev_bump, ev_hold;
  assign ev_clear = (act == ACT_CLEAR);
  assign ev_load  = (act == ACT_LOAD);
  assign ev_bump  = (act == ACT_BUMP);
  assign ev_hold  = (act == ACT_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      ar_q <= AR_ZERO;
    end else begin
      unique case (act)
        ACT_CLEAR: ar_q <= AR_ZERO;
        ACT_LOAD:  ar_q <= load_val;
        ACT_BUMP:  ar_q <= f_bump(ar_q);
        default:   ar_q <= ar_q;
      endcase
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $countones({ev_clear, ev_load, ev_bump, ev_hold}) == 1); // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    ev_clear |=> ar_q == AR_ZERO); // R6

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    ev_load |=> ar_q == $past(load_val)); // R4

  AST_BUMP_WRAP: assert property (@(posedge clk) disable iff (rst)
    ev_bump |=> ar_q == f_bump($past(ar_q))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ev_hold |=> $stable(ar_q)); // R9

endmodule

// File: rtl/addr_reg_gate.sv
module addr_reg_gate
  import addr_reg_pkg::*;
#(
  parameter int unsigned AR_W   = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_T  = 8,
  parameter int unsigned NUM_D  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_T-1:0]  t_slot,
  input  logic [NUM_D-1:0]  op_dec,
  input  logic              ind_bit,
  input  logic              intr_cyc,
  input  logic [AR_W-1:0]   pc_in,
  input  logic [DATA_W-1:0] ir_in,
  input  logic [DATA_W-1:0] mem_in,
  output logic [AR_W-1:0]   ar_q,
  output logic              ld_o,
  output logic              inc_o,
  output logic              clr_o
);

  ar_src_e src_sel;

  addr_ctl_decode #(
    .NUM_T (NUM_T),
    .NUM_D (NUM_D)
  ) u_decode (
    .t_slot   (t_slot),
    .op_dec   (op_dec),
    .ind_bit  (ind_bit),
    .intr_cyc (intr_cyc),
    .ld_o     (ld_o),
    .inc_o    (inc_o),
    .clr_o    (clr_o),
    .src_o    (src_sel)
  );

  addr_reg_core #(
    .AR_W   (AR_W),
    .DATA_W (DATA_W)
  ) u_core (
    .clk      (clk),
    .rst      (rst),
    .ld       (ld_o),
    .inc      (inc_o),
    .clr      (clr_o),
    .src      (src_sel),
    .pc_val   (pc_in),
    .ir_word  (ir_in),
    .mem_word (mem_in),
    .ar_q     (ar_q)
  );

  AST_FETCH_PC: assert property (@(posedge clk) disable iff (rst)
    (!intr_cyc && t_slot[0]) |=> ar_q == $past(pc_in)); // R3

  AST_CLEAR_BEATS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (clr_o && ld_o) |=> ar_q == '0); // R8

  AST_STROBE_SRC: assert property (@(posedge clk) disable iff (rst)
    ld_o |-> src_sel != SRC_NONE); // R2

endmodule

// File: tb/addr_reg_gate_bench.sv
`timescale 1ns/1ps
module addr_reg_gate_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  t_slot = '0;
  logic [7:0]  op_dec = '0;
  logic        ind_bit = 1'b0;
  logic        intr_cyc = 1'b0;
  logic [11:0] pc_in = '0;
  logic [15:0] ir_in = '0;
  logic [15:0] mem_in = '0;
  logic [11:0] ar_q;
  logic        ld_o, inc_o, clr_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [11:0] model = '0;
  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  addr_reg_gate u_addr_reg_gate (
    .clk(clk), .rst(rst), .t_slot(t_slot), .op_dec(op_dec), .ind_bit(ind_bit),
    .intr_cyc(intr_cyc), .pc_in(pc_in), .ir_in(ir_in), .mem_in(mem_in),
    .ar_q(ar_q), .ld_o(ld_o), .inc_o(inc_o), .clr_o(clr_o)
  );

  // Monitor: compare the register against the oldest prediction
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [11:0] e;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      n_cmp++;
      if (ar_q !== e) begin
        n_bad++;
        $display("FAIL %s ar_q actual=%03h expected=%03h", tg, ar_q, e);
      end
    end
  end

  // Driver: apply one cycle of stimulus, check strobes, push the prediction
  task automatic step(input logic [7:0] t, input logic [7:0] d, input logic i,
                      input logic r, input logic rs, input logic [11:0] pc,
                      input logic [15:0] ir, input logic [15:0] mw, input string tag);
    logic eld, einc, eclr;
    @(negedge clk);
    t_slot = t; op_dec = d; ind_bit = i; intr_cyc = r; rst = rs;
    pc_in = pc; ir_in = ir; mem_in = mw;
    eclr = r & t[0];
    eld  = (~r & (t[0] | t[2])) | (~d[7] & i & t[3]);
    einc = d[5] & t[4];
    #1;
    if (!rs) begin
      n_cmp++;
      if ({ld_o, inc_o, clr_o} !== {eld, einc, eclr}) begin
        n_bad++;
        $display("FAIL R2 (%s) strobes ld/inc/clr actual=%b%b%b expected=%b%b%b",
                 tag, ld_o, inc_o, clr_o, eld, einc, eclr);
      end
    end
    if (rs)                   model = 12'h000;
    else if (r && t[0])       model = 12'h000;
    else if (!r && t[0])      model = pc;
    else if (!r && t[2])      model = ir[11:0];
    else if (!d[7] && i && t[3]) model = mw[11:0];
    else if (d[5] && t[4])    model = (model == 12'hFFF) ? 12'h000 : model + 12'h001;
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  initial begin
    step(8'h00, 8'h00, 0, 0, 1, 12'h5A5, 16'h0, 16'h0, "R1 reset");
    step(8'h01, 8'h20, 1, 0, 1, 12'h5A5, 16'h0, 16'h0, "R1 reset");
    step(8'h01, 8'h00, 0, 0, 0, 12'h123, 16'h0, 16'h0, "R3 fetch pc");
    step(8'h04, 8'h00, 0, 0, 0, 12'h000, 16'hA456, 16'h0, "R4 ir field");
    step(8'h08, 8'h00, 1, 0, 0, 12'h000, 16'h0, 16'hB789, "R5 indirect");
    step(8'h08, 8'h80, 1, 0, 0, 12'h000, 16'h0, 16'h0111, "R9 regref no load");
    step(8'h08, 8'h00, 0, 0, 0, 12'h000, 16'h0, 16'h0222, "R9 direct no load");
    step(8'h10, 8'h20, 0, 0, 0, 12'h000, 16'h0, 16'h0, "R7 increment");
    step(8'h08, 8'h20, 0, 0, 0, 12'h000, 16'h0, 16'h0, "R9 d5 off phase");
    step(8'h01, 8'h00, 0, 0, 0, 12'hFFF, 16'h0, 16'h0, "R3 fetch top");
    step(8'h10, 8'h20, 0, 0, 0, 12'h000, 16'h0, 16'h0, "R7 wrap");
    step(8'h10, 8'h20, 0, 0, 0, 12'h000, 16'h0, 16'h0, "R7 after wrap");
    step(8'h00, 8'h00, 0, 0, 0, 12'h777, 16'h0, 16'h0, "R9 idle");
    step(8'h04, 8'h00, 0, 0, 0, 12'h000, 16'h0C3D, 16'h0, "R4 ir field");
    step(8'h01, 8'h00, 0, 1, 0, 12'h321, 16'h0, 16'h0, "R6 interrupt clear");
    step(8'h04, 8'h00, 0, 1, 0, 12'h000, 16'h0ABC, 16'h0, "R9 intr blocks decode");
    step(8'h01, 8'h00, 0, 0, 0, 12'h456, 16'h0, 16'h0, "R3 fetch pc");
    step(8'h09, 8'h00, 1, 1, 0, 12'h000, 16'h0, 16'h0999, "R8 clear over load");
    step(8'h14, 8'h20, 0, 0, 0, 12'h000, 16'h0654, 16'h0, "R8 load over inc");
    step(8'h05, 8'h00, 0, 0, 0, 12'h0AA, 16'h0BBB, 16'h0, "R8 pc over ir");
    step(8'h0C, 8'h00, 1, 0, 0, 12'h000, 16'h0DDD, 16'h0EEE, "R8 ir over mem");
    step(8'h18, 8'h20, 1, 0, 0, 12'h000, 16'h0, 16'h0F0F, "R8 mem over inc");
    step(8'h11, 8'h20, 0, 0, 1, 12'h333, 16'h0, 16'h0, "R1 mid-run reset");
    step(8'h10, 8'h20, 0, 0, 0, 12'h000, 16'h0, 16'h0, "R7 from zero");
    step(8'h00, 8'h00, 0, 0, 0, 12'h000, 16'h0, 16'h0, "R9 idle");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #20000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule